// File: doc/BRIEF.md
# Pipelined 3x3 Median Filter

This block takes a stream of pixel columns, three vertically adjacent unsigned pixels per clock, and produces the median of the 3-by-3 window formed by the newest valid column and the two valid columns before it. In an image pipeline, that median replaces the centre pixel of the window. Line buffering, frame edges and border replication are handled elsewhere. The block only ever sees complete columns.

Each column is sorted once, when it arrives, by a three-node compare-exchange group. Its sorted triple is then kept in a short history and reused for the next two window positions. A pruned merge network combines the three sorted columns. It takes the largest of the column minima, the median of the column middles and the smallest of the column maxima, and the median of those three values is the result. Nodes whose second output is not needed keep only one output. Every node decides by subtracting one operand from the other and steering its multiplexers with the borrow.

Top module: `median3x3_pipe`

## Requirements
- R1: When `median_valid` is high, `median` equals the fifth smallest (unsigned) of the nine pixels in the three most recent valid columns.
- R2: A valid column presented in cycle c, preceded by at least two valid columns since reset, gives `median_valid` high in cycle c+3 carrying the median of that window. `median_valid` is low in every other cycle.
- R3: The first two valid columns after reset only prime the window and never raise `median_valid`.
- R4: Cycles with `col_valid` low neither shift the window nor produce an output. The window is always the last three valid columns, however many idle cycles lie between them.
- R5: While `median_valid` is low, `median` keeps the last value it delivered.
- R6: With `rst_n` low at a rising edge (synchronous, active-low), the column history and the valid pipeline are cleared. `median_valid` and `median` then read 0, and three fresh valid columns are again needed.
- R7: Equal inputs give a fixed result. A window of nine equal pixels yields that pixel value, and ties anywhere resolve to the correct rank value.
- R8: Pixels compare as unsigned values over the full range 0 to 2^PIX_W-1, so 0 and the all-ones value rank as the extremes.
- R9: With `col_valid` held high after priming, one median is delivered in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| col_valid | input | 1 | The three pixel inputs hold a new column this cycle |
| px_top | input | PIX_W | Upper pixel of the incoming column |
| px_mid | input | PIX_W | Middle pixel of the incoming column |
| px_bot | input | PIX_W | Lower pixel of the incoming column |
| median_valid | output | 1 | `median` carries a new result this cycle |
| median | output | PIX_W | Median of the window, held between results |

## Verification
A column captured at a rising edge reaches the outputs after two further edges, so its result is visible in the third cycle after it was presented. The bench keeps a three-entry line of expected results, one per driven cycle. One time unit after each edge, it compares both outputs against the entry from two edges earlier. In cycles where that entry is not valid, the expected `median` is the last delivered value. Reset checks sample just after the edges that occur while `rst_n` is low.

// File: rtl/med_pkg.sv
// Package: shared constants and node variants for the median filter.
// Assumes a square window of WIN columns by WIN rows; the merge network
// in the top module is written for WIN = 3.
package med_pkg;
    localparam int WIN = 3;

    // Which single result a pruned compare node keeps.
    typedef enum logic {
        PICK_MIN = 1'b0,
        PICK_MAX = 1'b1
    } pick_e;
endpackage

// File: rtl/cmp_borrow.sv
// Module: cmp_borrow
// Subtracts y from x on W+1 bits and returns the borrow, which is high
// exactly when x < y (unsigned). This is the decision of every node.
module cmp_borrow #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic         borrow
);
    function automatic logic borrow_of(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] d;
        d = {1'b0, a} - {1'b0, b};
        return d[W];
    endfunction

    // Borrow of x - y drives the selects of the owning node.
    assign borrow = borrow_of(x, y);
endmodule

// File: rtl/cmp_swap.sv
// Module: cmp_swap
// Two-output compare-exchange node: smaller value on lo, larger on hi.
// Assumes unsigned operands; on a tie, a leaves on lo and b on hi.
module cmp_swap #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    logic b_below_a;

    cmp_borrow #(.W(W)) u_dec (
        .x      (b),
        .y      (a),
        .borrow (b_below_a)
    );

    // Route both operands by the single borrow decision.
    always_comb begin
        lo = b_below_a ? b : a;
        hi = b_below_a ? a : b;
    end
endmodule

// File: rtl/cmp_pick.sv
// Module: cmp_pick
// Pruned compare node that keeps one output, chosen by KIND.
// Tie behaviour matches cmp_swap (a is taken as the smaller).
module cmp_pick #(
    parameter int             W    = 8,
    parameter med_pkg::pick_e KIND = med_pkg::PICK_MIN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic b_below_a;

    cmp_borrow #(.W(W)) u_dec (
        .x      (b),
        .y      (a),
        .borrow (b_below_a)
    );

    generate
        if (KIND == med_pkg::PICK_MIN) begin : g_min
            // Keep the smaller operand only.
            assign y = b_below_a ? b : a;
        end else begin : g_max
            // Keep the larger operand only.
            assign y = b_below_a ? a : b;
        end
    endgenerate
endmodule

// File: rtl/col_sort3.sv
// Module: col_sort3
// Full sort of three values with three compare-exchange nodes.
// Pure combinational; outputs are ordered lo <= mid <= hi.
module col_sort3 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] lo,
    output logic [W-1:0] mid,
    output logic [W-1:0] hi
);
    logic [W-1:0] l_ab, h_ab, l_c;

    cmp_swap #(.W(W)) u_n0 (.a(a),    .b(b),   .lo(l_ab), .hi(h_ab));
    cmp_swap #(.W(W)) u_n1 (.a(h_ab), .b(c),   .lo(l_c),  .hi(hi));
    cmp_swap #(.W(W)) u_n2 (.a(l_ab), .b(l_c), .lo(lo),   .hi(mid));
endmodule

// File: rtl/med3_pick.sv
// Module: med3_pick
// Median of three values from one full node and two pruned nodes:
// y = max(min(a,b), min(max(a,b), c)). Combinational.
module med3_pick #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y
);
    logic [W-1:0] l_ab, h_ab, cap;

    cmp_swap #(.W(W)) u_s (.a(a), .b(b), .lo(l_ab), .hi(h_ab));
    cmp_pick #(.W(W), .KIND(med_pkg::PICK_MIN)) u_cap (.a(h_ab), .b(c),   .y(cap));
    cmp_pick #(.W(W), .KIND(med_pkg::PICK_MAX)) u_out (.a(l_ab), .b(cap), .y(y));
endmodule

// File: rtl/median3x3_pipe.sv
// Module: median3x3_pipe (top)
// Median of a 3x3 window built from the last three valid pixel columns.
// Pipeline: [capture sorted column] -> [merge to three candidates] ->
// [median of candidates]. Result due three cycles after its column.
// Assumes complete columns arrive from an external line buffer.
module median3x3_pipe #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             col_valid,
    input  logic [PIX_W-1:0] px_top,
    input  logic [PIX_W-1:0] px_mid,
    input  logic [PIX_W-1:0] px_bot,
    output logic             median_valid,
    output logic [PIX_W-1:0] median
);
    localparam int WIN    = med_pkg::WIN;
    localparam int FILL_W = $clog2(WIN);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(WIN - 1);

    typedef struct packed {
        logic [PIX_W-1:0] lo;
        logic [PIX_W-1:0] mid;
        logic [PIX_W-1:0] hi;
    } col_t;

    // ---------------- stage 0: sort the incoming column once ----------
    col_t              new_col;
    col_t              hist_q [WIN];
    logic [FILL_W-1:0] fill_q;
    logic              v0_q;
    logic              completes;

    col_sort3 #(.W(PIX_W)) u_entry (
        .a   (px_top),
        .b   (px_mid),
        .c   (px_bot),
        .lo  (new_col.lo),
        .mid (new_col.mid),
        .hi  (new_col.hi)
    );

    assign completes = col_valid && (fill_q == FILL_MAX);

    // Shift the sorted column into the history on each valid column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN; i++) hist_q[i] <= '0;
        end else if (col_valid) begin
            hist_q[0] <= new_col;
            for (int i = 1; i < WIN; i++) hist_q[i] <= hist_q[i-1];
        end
    end

    // Count priming columns and mark the column that completes a window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            v0_q   <= 1'b0;
        end else begin
            v0_q <= completes;
            if (col_valid && fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
        end
    end

    // ---------------- stage 1: reduce three columns to three candidates
    logic [PIX_W-1:0] col_lo  [WIN];
    logic [PIX_W-1:0] col_mid [WIN];
    logic [PIX_W-1:0] col_hi  [WIN];
    logic [PIX_W-1:0] lo_chain [WIN];
    logic [PIX_W-1:0] hi_chain [WIN];
    logic [PIX_W-1:0] mid_med;

    generate
        for (genvar g = 0; g < WIN; g++) begin : g_unpack
            assign col_lo[g]  = hist_q[g].lo;
            assign col_mid[g] = hist_q[g].mid;
            assign col_hi[g]  = hist_q[g].hi;
        end

        assign lo_chain[0] = col_lo[0];
        assign hi_chain[0] = col_hi[0];
        for (genvar g = 1; g < WIN; g++) begin : g_reduce
            // Largest of the column minima.
            cmp_pick #(.W(PIX_W), .KIND(med_pkg::PICK_MAX)) u_lomax (
                .a (lo_chain[g-1]), .b (col_lo[g]), .y (lo_chain[g])
            );
            // Smallest of the column maxima.
            cmp_pick #(.W(PIX_W), .KIND(med_pkg::PICK_MIN)) u_himin (
                .a (hi_chain[g-1]), .b (col_hi[g]), .y (hi_chain[g])
            );
        end
    endgenerate

    med3_pick #(.W(PIX_W)) u_midmed (
        .a (col_mid[0]),
        .b (col_mid[1]),
        .c (col_mid[2]),
        .y (mid_med)
    );

    logic [PIX_W-1:0] cand_lo_q, cand_mid_q, cand_hi_q;
    logic             v1_q;

    // Register the three candidates for a completed window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_lo_q  <= '0;
            cand_mid_q <= '0;
            cand_hi_q  <= '0;
            v1_q       <= 1'b0;
        end else begin
            v1_q <= v0_q;
            if (v0_q) begin
                cand_lo_q  <= lo_chain[WIN-1];
                cand_mid_q <= mid_med;
                cand_hi_q  <= hi_chain[WIN-1];
            end
        end
    end

    // ---------------- stage 2: median of the candidates ---------------
    logic [PIX_W-1:0] final_med;

    med3_pick #(.W(PIX_W)) u_final (
        .a (cand_lo_q),
        .b (cand_mid_q),
        .c (cand_hi_q),
        .y (final_med)
    );

    // Deliver the result; hold it while no new window is due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            median       <= '0;
            median_valid <= 1'b0;
        end else begin
            median_valid <= v1_q;
            if (v1_q) median <= final_med;
        end
    end
endmodule

// File: rtl/median3x3_chk.sv
// Module: median3x3_chk
// Port-level properties of median3x3_pipe. Keeps its own raw copy of the
// window and delays it to the output cycle to check the rank of the result.
module median3x3_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             col_valid,
    input logic [PIX_W-1:0] px_top,
    input logic [PIX_W-1:0] px_mid,
    input logic [PIX_W-1:0] px_bot,
    input logic             median_valid,
    input logic [PIX_W-1:0] median
);
    localparam int N = 9;

    logic [PIX_W-1:0] win_q [N];
    logic [PIX_W-1:0] d1_q  [N];
    logic [PIX_W-1:0] d2_q  [N];
    logic [1:0]       seen_q;
    logic [3:0]       n_less, n_le;

    // Raw window on valid columns, plus a two-cycle delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                win_q[i] <= '0;
                d1_q[i]  <= '0;
                d2_q[i]  <= '0;
            end
            seen_q <= '0;
        end else begin
            if (col_valid) begin
                win_q[0] <= px_top;
                win_q[1] <= px_mid;
                win_q[2] <= px_bot;
                for (int i = 3; i < N; i++) win_q[i] <= win_q[i-3];
                if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
            end
            for (int i = 0; i < N; i++) begin
                d1_q[i] <= win_q[i];
                d2_q[i] <= d1_q[i];
            end
        end
    end

    // Rank of the delivered value inside the delayed window.
    always_comb begin
        n_less = '0;
        n_le   = '0;
        for (int i = 0; i < N; i++) begin
            if (d2_q[i] <  median) n_less = n_less + 4'd1;
            if (d2_q[i] <= median) n_le   = n_le   + 4'd1;
        end
    end

    // R1 (and R4, R7, R8): the result has rank five in its window.
    p_rank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        median_valid |-> (n_less <= 4'd4 && n_le >= 4'd5));

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        median_valid |-> $past(col_valid, 3));

    p_prime_r3: assert property (@(posedge clk) disable iff (!rst_n)
        median_valid |-> (seen_q == 2'd3));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !median_valid |-> $stable(median));

    p_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!median_valid && median == '0));
endmodule

bind median3x3_pipe median3x3_chk #(.PIX_W(PIX_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .col_valid    (col_valid),
    .px_top       (px_top),
    .px_mid       (px_mid),
    .px_bot       (px_bot),
    .median_valid (median_valid),
    .median       (median)
);

// File: tb/test_median3x3_pipe.sv
// Bench for median3x3_pipe: table walk, then directed and random phases.
module test_median3x3_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    typedef struct packed {
        logic [W-1:0] t;
        logic [W-1:0] m;
        logic [W-1:0] b;
        logic         has_exp;
        logic [W-1:0] exp;
    } vec_t;

    // Columns in arrival order; exp is the median of the window ending there.
    localparam vec_t VECS [8] = '{
        '{8'd10,  8'd20,  8'd30,  1'b0, 8'd0},
        '{8'd40,  8'd50,  8'd60,  1'b0, 8'd0},
        '{8'd70,  8'd80,  8'd90,  1'b1, 8'd50},
        '{8'd0,   8'd255, 8'd5,   1'b1, 8'd60},
        '{8'd255, 8'd255, 8'd255, 1'b1, 8'd90},
        '{8'd1,   8'd1,   8'd1,   1'b1, 8'd5},
        '{8'd7,   8'd7,   8'd7,   1'b1, 8'd7},
        '{8'd200, 8'd3,   8'd100, 1'b1, 8'd7}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         col_valid = 1'b0;
    logic [W-1:0] px_top = '0, px_mid = '0, px_bot = '0;
    logic         median_valid;
    logic [W-1:0] median;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;
    string phase = "R1";

    logic [W-1:0] mw [9];
    int           mcount = 0;
    logic         pv [3];
    logic [W-1:0] pd [3];
    logic [W-1:0] last_d = '0;

    median3x3_pipe #(.PIX_W(W)) i_median3x3_pipe (
        .clk(clk), .rst_n(rst_n), .col_valid(col_valid),
        .px_top(px_top), .px_mid(px_mid), .px_bot(px_bot),
        .median_valid(median_valid), .median(median)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] ref_median();
        logic [W-1:0] s [9];
        logic [W-1:0] k;
        int j;
        for (int i = 0; i < 9; i++) s[i] = mw[i];
        for (int i = 1; i < 9; i++) begin
            k = s[i];
            j = i - 1;
            while (j >= 0 && s[j] > k) begin
                s[j+1] = s[j];
                j--;
            end
            s[j+1] = k;
        end
        return s[4];
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s (%s): actual=%0d expected=%0d at %0t", req, phase, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 9; i++) mw[i] = '0;
        for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pd[i] = '0; end
        mcount = 0;
        last_d = '0;
    endtask

    // One cycle: drive a column (or idle), then check the outputs that the
    // column presented two cycles earlier is due to produce now.
    task automatic step(input logic v, input logic [W-1:0] t, input logic [W-1:0] m,
                        input logic [W-1:0] b, input logic ovr, input logic [W-1:0] ovr_d);
        logic         nv;
        logic [W-1:0] nd;
        @(negedge clk);
        col_valid = v; px_top = t; px_mid = m; px_bot = b;
        @(posedge clk);
        #1;
        nv = 1'b0;
        nd = '0;
        if (v) begin
            for (int i = 8; i >= 3; i--) mw[i] = mw[i-3];
            mw[0] = t; mw[1] = m; mw[2] = b;
            mcount++;
            if (mcount >= 3) begin
                nv = 1'b1;
                nd = ovr ? ovr_d : ref_median();
            end
        end
        pv[2] = pv[1]; pv[1] = pv[0]; pv[0] = nv;
        pd[2] = pd[1]; pd[1] = pd[0]; pd[0] = nd;
        if (pv[2]) last_d = pd[2];
        check((mcount < 3) ? "R3" : "R2", W'(median_valid), W'(pv[2]));
        check(pv[2] ? "R1" : "R5", median, last_d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        col_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R6", W'(median_valid), '0);
        check("R6", median, '0);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();

        // Table walk: R1 medians, R8 extreme values, R7 equal columns.
        phase = "R8";
        foreach (VECS[i]) step(1'b1, VECS[i].t, VECS[i].m, VECS[i].b, VECS[i].has_exp, VECS[i].exp);
        phase = "R5";
        repeat (5) step(1'b0, 8'd99, 8'd99, 8'd99, 1'b0, '0);

        // R6: reset mid-stream, then R3: two columns alone never complete.
        do_reset();
        phase = "R3";
        step(1'b1, 8'd9, 8'd8, 8'd7, 1'b0, '0);
        step(1'b0, 8'd0, 8'd0, 8'd0, 1'b0, '0);
        step(1'b1, 8'd6, 8'd5, 8'd4, 1'b0, '0);
        repeat (4) step(1'b0, 8'd0, 8'd0, 8'd0, 1'b0, '0);

        // R4: random columns with idle gaps.
        phase = "R4";
        for (int n = 0; n < 400; n++) begin
            logic v;
            v = ($urandom_range(0, 3) != 0);
            step(v, W'($urandom_range(0, 255)), W'($urandom_range(0, 255)),
                 W'($urandom_range(0, 255)), 1'b0, '0);
        end

        // R9: continuous columns, one result per cycle.
        phase = "R9";
        for (int n = 0; n < 200; n++)
            step(1'b1, W'($urandom_range(0, 255)), W'($urandom_range(0, 255)),
                 W'($urandom_range(0, 255)), 1'b0, '0);

        // R7: all-equal windows and heavy ties.
        phase = "R7";
        for (int n = 0; n < 60; n++) begin
            logic [W-1:0] q;
            q = W'($urandom_range(0, 3) * 85);
            step(1'b1, q, q, (n % 5 == 0) ? W'($urandom_range(0, 255)) : q, 1'b0, '0);
        end

        // R8: alternating extremes.
        phase = "R8";
        for (int n = 0; n < 30; n++)
            step(1'b1, (n % 2 == 0) ? 8'd0 : 8'd255, 8'd255, (n % 3 == 0) ? 8'd0 : 8'd128, 1'b0, '0);
        phase = "R5";
        repeat (5) step(1'b0, 8'd1, 8'd2, 8'd3, 1'b0, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule